// File: doc/BRIEF.md
# Configuration Port Streaming DMA Master

This block feeds a 32-bit internal configuration port from a data FIFO at a rate of one word per clock. A control FSM or software starts an operation by giving a word count and a base address. The block hands these two values, as a single descriptor pulse, to a companion reader on the memory side. That reader fetches the words and fills the FIFO. This block never drives memory. Between the two controllers only data moves.

After it forwards the descriptor, the block waits for the FIFO to report data. It then pops one word per cycle and writes each word to the configuration port one cycle later, when the FIFO's registered output presents it. If the FIFO runs dry partway through, the write strobe drops and the remaining count holds until words come back. When the last word has been written, the block returns to idle and pulses done for one cycle. A request for zero words completes at once, and no descriptor is sent.

Each write carries four bytes, so a 100 MHz clock reaches 400 MB/s when the FIFO never runs empty.

Top module: `cfg_stream_dma`

## Requirements
- R1: A start accepted in idle with a non-zero count gives, in the next cycle, a one-cycle `desc_valid_o` pulse carrying the latched address and count, and `busy_o` goes high in that same cycle.
- R2: While `fifo_empty_i` is high, `fifo_rd_o` stays low. Before the FIFO first reports data, no configuration write occurs.
- R3: `cfg_wr_o` is high exactly one cycle after each cycle with `fifo_rd_o` high. It carries that popped word on `cfg_data_o`, in FIFO order. While the FIFO stays non-empty, the writes are back to back.
- R4: An operation pops exactly the requested number of words and writes exactly that many. Words left in the FIFO beyond the count are not read, and `fifo_rd_o` stays low while idle.
- R5: If the FIFO goes empty mid-transfer, writes pause, `busy_o` stays high, and the transfer resumes and completes once data returns.
- R6: `done_o` is a single-cycle pulse in the cycle after the final write, and `busy_o` is low in that cycle.
- R7: A start while busy is ignored: no new descriptor and no extra words.
- R8: A start with a count of zero gives `done_o` in the next cycle. It produces no descriptor, no FIFO read and no busy.
- R9: After reset, `busy_o`, `done_o`, `desc_valid_o`, `fifo_rd_o` and `cfg_wr_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request |
| start_addr_i | input | 32 | Base address of the bitstream |
| start_len_i | input | 20 | Number of 32-bit words to move |
| desc_valid_o | output | 1 | Descriptor pulse to the memory-side reader |
| desc_addr_o | output | 32 | Descriptor base address |
| desc_len_o | output | 20 | Descriptor word count |
| fifo_empty_i | input | 1 | FIFO has no data |
| fifo_rd_o | output | 1 | FIFO pop; data is presented on the next cycle |
| fifo_data_i | input | 32 | FIFO registered read data |
| cfg_wr_o | output | 1 | Configuration port write strobe |
| cfg_data_o | output | 32 | Configuration port write word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The descriptor is due one cycle after the clock edge that samples the start. Each configuration write is due one cycle after its FIFO pop, and done is due one cycle after the final write. The bench drives inputs just after the falling edge and samples every output at the falling edge. It logs the cycle number of each write and each done pulse, so these spacings are checked exactly rather than with a tolerance. A scoreboard queue holds the words in the order they were pushed into the modelled FIFO, and each write is popped from it and compared. This catches both reordering and a write strobe that is misaligned with its data.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;

    parameter int unsigned DATA_W = 32;
    parameter int unsigned ADDR_W = 32;
    parameter int unsigned LEN_W  = 20;

    localparam int unsigned BYTES_PER_WORD = DATA_W / 8;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef struct packed {
        addr_t base;
        len_t  words;
    } desc_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } xfer_state_t;

    function automatic logic len_is_zero(input len_t l);
        return (l == '0);
    endfunction

    function automatic logic len_is_one(input len_t l);
        return (l == len_t'(1));
    endfunction

    function automatic len_t len_dec(input len_t l);
        return l - len_t'(1);
    endfunction

endpackage

// File: rtl/cfg_dma_ctrl.sv
module cfg_dma_ctrl
    import cfg_dma_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  desc_t req_i,
    input  logic  last_wr_i,
    output logic  load_o,
    output logic  busy_o,
    output desc_t desc_o,
    output logic  desc_valid_o,
    output logic  done_o
);

    xfer_state_t state_q;
    logic        accept;
    logic        zero_req;

    assign accept   = (state_q == ST_IDLE) && start_i && !len_is_zero(req_i.words);
    assign zero_req = (state_q == ST_IDLE) && start_i &&  len_is_zero(req_i.words);
    assign load_o   = accept;
    assign busy_o   = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            desc_o       <= '0;
            desc_valid_o <= 1'b0;
            done_o       <= 1'b0;
        end else begin
            desc_valid_o <= accept;
            done_o       <= zero_req || ((state_q == ST_RUN) && last_wr_i);
            if (accept) begin
                desc_o <= req_i;
            end
            case (state_q)
                ST_IDLE: if (accept)    state_q <= ST_RUN;
                ST_RUN:  if (last_wr_i) state_q <= ST_IDLE;
                default:                state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfg_dma_reader.sv
module cfg_dma_reader
    import cfg_dma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  len_t len_i,
    input  logic active_i,
    input  logic fifo_empty_i,
    output logic fifo_rd_o
);

    len_t pop_left_q;

    assign fifo_rd_o = active_i && !fifo_empty_i && !len_is_zero(pop_left_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pop_left_q <= '0;
        end else if (load_i) begin
            pop_left_q <= len_i;
        end else if (fifo_rd_o) begin
            pop_left_q <= len_dec(pop_left_q);
        end
    end

endmodule

// File: rtl/cfg_dma_writer.sv
module cfg_dma_writer
    import cfg_dma_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  len_t  len_i,
    input  logic  rd_i,
    input  word_t fifo_data_i,
    output logic  cfg_wr_o,
    output word_t cfg_data_o,
    output logic  last_o
);

    logic wr_q;
    len_t deliver_left_q;

    assign cfg_wr_o   = wr_q;
    assign cfg_data_o = wr_q ? fifo_data_i : '0;
    assign last_o     = wr_q && len_is_one(deliver_left_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q           <= 1'b0;
            deliver_left_q <= '0;
        end else begin
            wr_q <= rd_i;
            if (load_i) begin
                deliver_left_q <= len_i;
            end else if (wr_q) begin
                deliver_left_q <= len_dec(deliver_left_q);
            end
        end
    end

endmodule

// File: rtl/cfg_stream_dma.sv
module cfg_stream_dma
    import cfg_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [LEN_W-1:0]  start_len_i,
    output logic              desc_valid_o,
    output logic [ADDR_W-1:0] desc_addr_o,
    output logic [LEN_W-1:0]  desc_len_o,
    input  logic              fifo_empty_i,
    output logic              fifo_rd_o,
    input  logic [DATA_W-1:0] fifo_data_i,
    output logic              cfg_wr_o,
    output logic [DATA_W-1:0] cfg_data_o,
    output logic              busy_o,
    output logic              done_o
);

    desc_t req;
    desc_t desc;
    logic  load;
    logic  last_wr;
    logic  rd;

    assign req.base  = start_addr_i;
    assign req.words = start_len_i;

    cfg_dma_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .req_i        (req),
        .last_wr_i    (last_wr),
        .load_o       (load),
        .busy_o       (busy_o),
        .desc_o       (desc),
        .desc_valid_o (desc_valid_o),
        .done_o       (done_o)
    );

    cfg_dma_reader u_reader (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load),
        .len_i        (start_len_i),
        .active_i     (busy_o),
        .fifo_empty_i (fifo_empty_i),
        .fifo_rd_o    (rd)
    );

    cfg_dma_writer u_writer (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .len_i       (start_len_i),
        .rd_i        (rd),
        .fifo_data_i (fifo_data_i),
        .cfg_wr_o    (cfg_wr_o),
        .cfg_data_o  (cfg_data_o),
        .last_o      (last_wr)
    );

    assign fifo_rd_o   = rd;
    assign desc_addr_o = desc.base;
    assign desc_len_o  = desc.words;

endmodule

// File: rtl/cfg_stream_dma_chk.sv
module cfg_stream_dma_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic desc_valid_o,
    input logic fifo_empty_i,
    input logic fifo_rd_o,
    input logic cfg_wr_o,
    input logic busy_o,
    input logic done_o
);

    AST_DESC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        desc_valid_o |=> !desc_valid_o);                         // R1
    AST_DESC_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        desc_valid_o |-> busy_o);                                // R1
    AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (rst)
        fifo_empty_i |-> !fifo_rd_o);                            // R2
    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_o |=> cfg_wr_o);                                 // R3
    AST_NO_WRITE_UNREAD: assert property (@(posedge clk) disable iff (rst)
        !fifo_rd_o |=> !cfg_wr_o);                               // R3
    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !fifo_rd_o);                                 // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                     // R6
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);                                     // R6
    AST_START_BUSY_NO_DESC: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy_o) |=> !desc_valid_o);                  // R7

endmodule

bind cfg_stream_dma cfg_stream_dma_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .desc_valid_o (desc_valid_o),
    .fifo_empty_i (fifo_empty_i),
    .fifo_rd_o    (fifo_rd_o),
    .cfg_wr_o     (cfg_wr_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/cfg_stream_dma_tb.sv
`timescale 1ns/100ps
module cfg_stream_dma_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic [19:0] start_len_i = '0;
    logic        desc_valid_o;
    logic [31:0] desc_addr_o;
    logic [19:0] desc_len_o;
    logic        fifo_empty_i = 1'b1;
    logic        fifo_rd_o;
    logic [31:0] fifo_data_i = '0;
    logic        cfg_wr_o;
    logic [31:0] cfg_data_o;
    logic        busy_o;
    logic        done_o;

    always #2.5 clk = ~clk;

    cfg_stream_dma u_dut (.*);

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    logic [31:0] fifo_q[$];
    logic [31:0] exp_q[$];
    bit          stall = 0;
    bit          rd_seen = 0;
    bit          nxt_empty = 1;
    logic [31:0] nxt_data = '0;

    int wr_count = 0, rd_count = 0, desc_count = 0, done_count = 0;
    int first_wr_cyc = -1, last_wr_cyc = -1, done_cyc = -1;

    always @(posedge clk) cyc <= cyc + 1;

    // FIFO model: one-cycle registered read latency
    always @(negedge clk) begin
        rd_seen = fifo_rd_o;
        if (rd_seen) nxt_data = (fifo_q.size() > 0) ? fifo_q.pop_front() : 32'hBAD0_BAD0;
        nxt_empty = stall || (fifo_q.size() == 0);
    end
    always @(posedge clk) begin
        if (rd_seen) fifo_data_i <= nxt_data;
        fifo_empty_i <= nxt_empty;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (cfg_wr_o) begin
                logic [31:0] e;
                wr_count++;
                if (first_wr_cyc < 0) first_wr_cyc = cyc;
                last_wr_cyc = cyc;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hFFFF_FFFF;
                chk(cfg_data_o == e, "R3 data order", cfg_data_o, e);
            end
            if (fifo_rd_o)    rd_count++;
            if (desc_valid_o) desc_count++;
            if (done_o) begin
                done_count++;
                done_cyc = cyc;
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #0.2;
    endtask

    task automatic push_words(input int n, input logic [31:0] seed);
        for (int i = 0; i < n; i++) begin
            fifo_q.push_back(seed + 32'(i));
            exp_q.push_back(seed + 32'(i));
        end
    endtask

    task automatic pulse_start(input logic [31:0] a, input logic [19:0] n);
        start_i = 1'b1; start_addr_i = a; start_len_i = n;
        tick();
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 500; i++) begin
            if (done_o) return;
            tick();
        end
    endtask

    task automatic reset_marks();
        first_wr_cyc = -1; last_wr_cyc = -1; done_cyc = -1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        summary();
    end

    initial begin
        int w0, d0, r0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R9 reset state
        chk(!busy_o && !done_o && !desc_valid_o && !fifo_rd_o && !cfg_wr_o, "R9 reset outputs",
            {busy_o, done_o, desc_valid_o, fifo_rd_o, cfg_wr_o}, 0);

        // Full-speed transfer with extra words left in the FIFO
        push_words(8, 32'h1000_0000);
        repeat (2) tick();
        reset_marks(); w0 = wr_count; r0 = rd_count;
        pulse_start(32'h0004_0000, 20'd6);
        chk(desc_valid_o && busy_o, "R1 desc pulse", {desc_valid_o, busy_o}, 3);
        chk(desc_addr_o == 32'h0004_0000, "R1 desc addr", desc_addr_o, 32'h0004_0000);
        chk(desc_len_o == 20'd6, "R1 desc len", desc_len_o, 6);
        tick();
        chk(!desc_valid_o, "R1 desc single cycle", desc_valid_o, 0);
        wait_done();
        chk(wr_count - w0 == 6, "R4 write count", wr_count - w0, 6);
        chk(rd_count - r0 == 6, "R4 read count", rd_count - r0, 6);
        chk(last_wr_cyc - first_wr_cyc == 5, "R3 back-to-back", last_wr_cyc - first_wr_cyc, 5);
        chk(done_cyc == last_wr_cyc + 1, "R6 done timing", done_cyc, last_wr_cyc + 1);
        chk(!busy_o, "R6 idle at done", busy_o, 0);
        tick();
        chk(!done_o, "R6 done single cycle", done_o, 0);
        repeat (3) tick();
        chk(fifo_q.size() == 2, "R4 leftover words untouched", fifo_q.size(), 2);
        fifo_q.delete(); exp_q.delete();
        repeat (2) tick();

        // No read while FIFO reports empty
        stall = 1;
        push_words(4, 32'h2000_0000);
        w0 = wr_count; r0 = rd_count;
        pulse_start(32'h0008_0000, 20'd4);
        repeat (6) tick();
        chk(wr_count == w0 && rd_count == r0, "R2 hold while empty", wr_count - w0, 0);
        chk(busy_o, "R2 busy while waiting", busy_o, 1);
        stall = 0;
        wait_done();
        chk(wr_count - w0 == 4, "R2 completes after data", wr_count - w0, 4);
        repeat (2) tick();

        // Mid-transfer underrun
        push_words(3, 32'h3000_0000);
        repeat (2) tick();
        w0 = wr_count; d0 = done_count;
        pulse_start(32'h000C_0000, 20'd6);
        repeat (10) tick();
        chk(wr_count - w0 == 3, "R5 paused after underrun", wr_count - w0, 3);
        chk(busy_o && done_count == d0, "R5 still busy", busy_o, 1);
        push_words(3, 32'h3000_0003);
        wait_done();
        chk(wr_count - w0 == 6, "R5 resumes to completion", wr_count - w0, 6);
        repeat (2) tick();

        // Start while busy is ignored
        push_words(4, 32'h4000_0000);
        repeat (2) tick();
        w0 = wr_count; d0 = desc_count;
        pulse_start(32'h0010_0000, 20'd4);
        pulse_start(32'h0020_0000, 20'd2);
        wait_done();
        repeat (6) tick();
        chk(desc_count - d0 == 1, "R7 single descriptor", desc_count - d0, 1);
        chk(wr_count - w0 == 4, "R7 no extra words", wr_count - w0, 4);
        chk(!busy_o, "R7 idle after", busy_o, 0);

        // Zero-length request
        w0 = wr_count; d0 = desc_count; r0 = rd_count;
        push_words(2, 32'h5000_0000);
        repeat (2) tick();
        pulse_start(32'h0030_0000, 20'd0);
        chk(done_o && !busy_o && !desc_valid_o, "R8 immediate done",
            {done_o, busy_o, desc_valid_o}, 4);
        tick();
        chk(!done_o, "R8 done single cycle", done_o, 0);
        repeat (3) tick();
        chk(desc_count == d0 && rd_count == r0 && wr_count == w0, "R8 no traffic",
            rd_count - r0, 0);

        summary();
    end

endmodule